// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block is the transmit half of an asynchronous serial port that sends frames in the multiprocessor format. Each frame carries a low start bit, a 7- or 8-bit data field sent least-significant bit first, and one address/data flag bit. The flag tells receivers whether the frame is an address or a data byte. One or two high stop bits close the frame. Baud generation sits outside the block: a one-cycle `bit_tick_i` pulse marks each bit boundary.

The CPU writes a byte and its flag into a single holding register, which clears the empty and end flags. The transmitter moves the held byte into its shift register at a bit boundary and marks the holder empty, so the CPU can refill it while the current frame is on the line. When the first stop bit begins, the transmitter looks at the holder. If a byte is waiting, it is loaded at once and its start bit follows the last stop bit with no gap. If nothing is waiting, the end flag is raised and the line returns to the high idle level. The empty and end flags each drive a level interrupt gated by its own enable.

Top module: `mp_uart_tx`

## Requirements
- R1: While `en_i` is 0, `txd_o` is 1 from the next cycle on, and `empty_o` and `tend_o` read 1. Writes are ignored, so `empty_o` stays 1 after the transmitter is enabled again.
- R2: A write (`wr_en_i`=1 while enabled) stores `wr_data_i` and `wr_mpb_i` and clears both `empty_o` and `tend_o` on the next cycle.
- R3: In idle with a byte held, the next `bit_tick_i` loads the shift register, sets `empty_o` to 1 and drives the start bit (`txd_o`=0).
- R4: After the start bit come the data bits, least-significant bit first. There are 8 when `seven_bit_i`=0, and 7 (bits 0..6, with bit 7 ignored) when `seven_bit_i`=1.
- R5: The bit after the last data bit equals the `wr_mpb_i` value written with that byte.
- R6: The flag bit is followed by one stop bit (`two_stop_i`=0) or two stop bits (`two_stop_i`=1), each driven as 1.
- R7: If a byte is held when the first stop bit begins, it is loaded on that tick, `empty_o` rises, and its start bit begins on the tick right after the last stop bit.
- R8: If no byte is held when the first stop bit begins, `tend_o` is set on that tick, and after the stop bits `txd_o` stays 1 until a new start bit.
- R9: `txd_o` changes only on a cycle after `bit_tick_i`=1, so each bit lasts exactly one tick period.
- R10: `empty_irq_o` = `empty_o` AND `empty_ie_i`, and `end_irq_o` = `tend_o` AND `end_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Transmitter enable |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| seven_bit_i | input | 1 | 1 selects a 7-bit data field |
| two_stop_i | input | 1 | 1 selects two stop bits |
| wr_en_i | input | 1 | CPU write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| wr_mpb_i | input | 1 | Address/data flag sent with the byte |
| empty_ie_i | input | 1 | Enable for the empty interrupt |
| end_ie_i | input | 1 | Enable for the end interrupt |
| txd_o | output | 1 | Serial output, idle high |
| empty_o | output | 1 | Holding register empty flag |
| tend_o | output | 1 | Transmission end flag |
| empty_irq_o | output | 1 | Empty interrupt request |
| end_irq_o | output | 1 | End interrupt request |

## Verification
The bench sweeps both data widths, both stop counts and both flag values over several byte patterns. In every case a second byte is written right after the first one starts, so that it chains through the stop-bit check. A design that samples the holder at the wrong bit would leave an idle gap between frames, or would raise `tend_o` while a byte is still waiting. A design with an off-by-one in the data counter would send one data bit too many or too few in 7-bit mode and shift the flag bit. A design that accepted writes while disabled would clear `empty_o` and send a stale frame after being enabled again.

// File: rtl/mp_uart_tx_pkg.sv
package mp_uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_MPB, ST_STOP1, ST_STOP2
  } tx_state_e;
endpackage

// File: rtl/mp_uart_tx_buf.sv
module mp_uart_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_mpb_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      mpb_o   <= 1'b0;
      empty_o <= 1'b1;
    end else if (!en_i) begin
      empty_o <= 1'b1;
    end else if (wr_en_i) begin
      // a write wins over a load in the same cycle: old byte shifts, new one waits
      data_o  <= wr_data_i;
      mpb_o   <= wr_mpb_i;
      empty_o <= 1'b0;
    end else if (load_i) begin
      empty_o <= 1'b1;
    end
  end

  assert_write_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_en_i) |=> !empty_o);
  assert_empty_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> ($past(load_i) || !$past(en_i)));
endmodule

// File: rtl/mp_uart_tx_seq.sv
module mp_uart_tx_seq
  import mp_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_tick_i,
  input  logic              seven_bit_i,
  input  logic              two_stop_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic              buf_mpb_i,
  input  logic              buf_empty_i,
  output logic              load_o,
  output logic              txd_o,
  output logic              tend_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic              mpb_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q;
  logic              set_end;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = seven_bit_i ? LAST_SHORT : LAST_FULL;
  assign load_o   = en_i && bit_tick_i && !buf_empty_i &&
                    (state_q == ST_IDLE || state_q == ST_MPB);
  assign set_end  = en_i && bit_tick_i && buf_empty_i && (state_q == ST_MPB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      mpb_q   <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      txd_o   <= 1'b1;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      txd_o   <= 1'b1;
    end else if (bit_tick_i) begin
      if (load_o) begin
        shift_q <= buf_data_i;
        mpb_q   <= buf_mpb_i;
      end
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          txd_o   <= 1'b0;
          state_q <= ST_START;
        end
        ST_START: begin
          txd_o   <= shift_q[0];
          shift_q <= shift_q >> 1;
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt_q == last_idx) begin
            txd_o   <= mpb_q;
            state_q <= ST_MPB;
          end else begin
            txd_o   <= shift_q[0];
            shift_q <= shift_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_MPB: begin
          // stop bit begins here: holder state decides chaining
          txd_o   <= 1'b1;
          pend_q  <= load_o;
          state_q <= ST_STOP1;
        end
        ST_STOP1: begin
          if (two_stop_i) begin
            txd_o   <= 1'b1;
            state_q <= ST_STOP2;
          end else begin
            txd_o   <= !pend_q;
            state_q <= pend_q ? ST_START : ST_IDLE;
          end
        end
        ST_STOP2: begin
          txd_o   <= !pend_q;
          state_q <= pend_q ? ST_START : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tend_o <= 1'b1;
    else if (!en_i)    tend_o <= 1'b1;
    else if (wr_en_i)  tend_o <= 1'b0;
    else if (set_end)  tend_o <= 1'b1;
  end

  assert_mark_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> txd_o);
  assert_end_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_o) |-> ($past(bit_tick_i) || !$past(en_i)));
  assert_hold_between_ticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_tick_i) |=> $stable(txd_o));
  assert_idle_is_mark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> txd_o);
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_tick_i,
  input  logic              seven_bit_i,
  input  logic              two_stop_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_mpb_i,
  input  logic              empty_ie_i,
  input  logic              end_ie_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              tend_o,
  output logic              empty_irq_o,
  output logic              end_irq_o
);
  logic [DATA_W-1:0] buf_data;
  logic              buf_mpb;
  logic              load;

  mp_uart_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .en_i, .wr_en_i, .wr_data_i, .wr_mpb_i,
    .load_i  (load),
    .data_o  (buf_data),
    .mpb_o   (buf_mpb),
    .empty_o (empty_o)
  );

  mp_uart_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .en_i, .bit_tick_i, .seven_bit_i, .two_stop_i, .wr_en_i,
    .buf_data_i  (buf_data),
    .buf_mpb_i   (buf_mpb),
    .buf_empty_i (empty_o),
    .load_o      (load),
    .txd_o       (txd_o),
    .tend_o      (tend_o)
  );

  assign empty_irq_o = empty_o & empty_ie_i;
  assign end_irq_o   = tend_o & end_ie_i;
endmodule

// File: tb/mp_uart_tx_tb_top.sv
module mp_uart_tx_tb_top;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, tick = 1'b0, sev = 1'b0, two = 1'b0, wr = 1'b0, mpb = 1'b0;
  logic eie = 1'b0, tie = 1'b0;
  logic [7:0] wdata = '0;
  logic txd, empty, tend, eirq, tirq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mp_uart_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_tick_i(tick),
    .seven_bit_i(sev), .two_stop_i(two), .wr_en_i(wr), .wr_data_i(wdata),
    .wr_mpb_i(mpb), .empty_ie_i(eie), .end_ie_i(tie),
    .txd_o(txd), .empty_o(empty), .tend_o(tend),
    .empty_irq_o(eirq), .end_irq_o(tirq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic gap();
    repeat (DIV - 2) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d, input logic m);
    @(negedge clk) begin wr = 1'b1; wdata = d; mpb = m; end
    @(negedge clk) wr = 1'b0;
  endtask

  function automatic logic fbit(input logic [7:0] d, input logic m, input int nb, input int pos);
    if (pos == 0) return 1'b0;
    if (pos <= nb) return d[pos-1];
    if (pos == nb + 1) return m;
    return 1'b1;
  endfunction

  task automatic run_case(input logic s7, input logic s2, input logic m0,
                          input logic [7:0] d0, input logic [7:0] d1);
    int nb, ns, len;
    logic exp_txd, exp_e, exp_t;
    nb = s7 ? 7 : 8;
    ns = s2 ? 2 : 1;
    len = nb + 2 + ns;
    sev = s7; two = s2;
    write(d0, m0);
    chk("R2 empty cleared", 32'(empty), 0);
    chk("R2 end cleared", 32'(tend), 0);
    for (int i = 1; i <= 2 * len + 2; i++) begin
      do_tick();
      if (i <= len)          exp_txd = fbit(d0, m0, nb, i - 1);
      else if (i <= 2 * len) exp_txd = fbit(d1, !m0, nb, i - len - 1);
      else                   exp_txd = 1'b1;
      exp_e = (i == 1) ? 1'b1 : (i >= nb + 3);
      exp_t = (i >= len + nb + 3);
      if (i == 1) chk("R3 start bit", 32'(txd), 0);
      else if (i == len + 1) chk("R7 chained start no gap", 32'(txd), 0);
      else if (i > 2 * len) chk("R8 mark after end", 32'(txd), 1);
      else if ((i - 1) % len == nb + 1 || (i - 1 - len) == nb + 1)
        chk("R5 flag bit", 32'(txd), 32'(exp_txd));
      else if ((i - 1) % len > nb + 1 || i == len)
        chk("R6 stop bit", 32'(txd), 32'(exp_txd));
      else
        chk("R4 data bit", 32'(txd), 32'(exp_txd));
      chk("R7 empty flag", 32'(empty), 32'(exp_e));
      chk("R8 end flag", 32'(tend), 32'(exp_t));
      chk("R10 empty irq", 32'(eirq), 32'(exp_e & eie));
      chk("R10 end irq", 32'(tirq), 32'(exp_t & tie));
      gap();
      chk("R9 bit held between ticks", 32'(txd), 32'(exp_txd));
      if (i == 1) write(d1, !m0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    int k;
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h81; pats[3] = 8'h7E;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", 32'(txd), 1);
    chk("R1 reset empty", 32'(empty), 1);
    chk("R1 reset end", 32'(tend), 1);
    rst_n = 1'b1;
    @(negedge clk) en = 1'b1;
    k = 0;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 4; p++) begin
            eie = k[0]; tie = k[1];
            run_case(a[0], b[0], c[0], pats[p], ~pats[p] ^ 8'(k));
            k++;
          end
    // disable mid-frame and writes while disabled
    sev = 1'b0; two = 1'b0;
    write(8'h00, 1'b0);
    do_tick(); do_tick();
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk("R1 disabled txd", 32'(txd), 1);
    chk("R1 disabled empty", 32'(empty), 1);
    chk("R1 disabled end", 32'(tend), 1);
    write(8'h00, 1'b0);
    chk("R1 write ignored", 32'(empty), 1);
    @(negedge clk) en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      do_tick();
      chk("R1 no stale frame", 32'(txd), 1);
      chk("R1 still empty", 32'(empty), 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule